// File: doc/BRIEF.md
# Serial MII Transmit Serializer

This block is the MAC-side transmit end of a serial media-independent interface that runs entirely from one 125 MHz reference clock. It takes bytes from a valid/ready byte interface, where each byte carries its own frame-enable and error flag. It sends them as ten-bit segments on a single data line. A separate sync line pulses at the start of every segment, without a break, whether or not a frame is in progress.

In 100 Mbps mode every segment carries a fresh byte. In 10 Mbps mode each segment is replayed ten times before the next byte is taken. The speed request input is only honoured at a point where the segment being loaded has its enable bit clear, so a frame is never split across two speeds. The ready output is a one-cycle pulse in the last bit cycle before a new segment is loaded. When no byte is offered at that moment, the block sends an idle segment with every bit low.

Top module: `serial_mii_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the sync output is high, the data output is low and ready is low; the block leaves reset in 100 Mbps mode.
- R2: The sync output is high for exactly one clock in every 10 clocks, counted from reset release, with or without a frame in progress.
- R3: A segment occupies the 10 cycles starting at the sync cycle, in this order: segment bit 0 is the error flag (in the sync cycle), bit 1 is the enable flag, and bits 2 to 9 carry data bits 0 to 7, least significant first.
- R4: Ready is only ever high in the last bit cycle of a segment, and only for one cycle at a time. A byte that is valid in that cycle is sent in the segment that starts in the next cycle.
- R5: In 10 Mbps mode, each loaded segment is sent 10 times in a row, and ready rises only in the last bit of the tenth copy.
- R6: In 100 Mbps mode, a new segment is loaded at every segment boundary and the error flag is passed through unchanged.
- R7: In 10 Mbps mode, the error bit of every segment is low, whatever the error flag of the byte.
- R8: When no byte is valid at a load point, the next segment is all zeros, so the enable bit is clear in the segment after a frame's last byte.
- R9: The speed request input (high for 10 Mbps) is taken at a load point only if the segment loaded there has its enable bit clear. A change made while enable-set bytes are being loaded is ignored until the first such idle load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_slow | input | 1 | Requested speed: 1 selects 10 Mbps, 0 selects 100 Mbps |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | One-cycle pulse; the offered byte is taken at the next rising edge |
| in_data | input | 8 | Byte to send |
| in_en | input | 1 | Byte belongs to a frame (segment enable bit) |
| in_err | input | 1 | Byte is marked in error (segment error bit, 100 Mbps only) |
| ser_data | output | 1 | Serial segment data line |
| ser_sync | output | 1 | Segment sync pulse, high in the first bit cycle of every segment |

## Verification
Two functions of this block meet in the same cycle. The last bit of a segment is both the cycle that hands out a byte through ready and, when the loaded segment is idle, the cycle that latches a new speed request. Both then take effect together at the next sync. The bench provokes this by changing the speed request in the middle of a frame in each mode. It then lets the frame end and gives the request its idle load point. A scoreboard checks every segment that follows, one copy per segment in 100 Mbps mode and ten copies in 10 Mbps mode. A wrong switch point shows up as a segment with the wrong repeat count or a stray error bit.

// File: rtl/serial_mii_tx_pkg.sv
package serial_mii_tx_pkg;

  localparam int DATA_W = 8;
  localparam int SEG_W  = DATA_W + 2;

  // Packed so that bit 0 is the error flag, bit 1 the enable flag and
  // bits 2..9 the data byte, least significant bit first on the wire.
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              en;
    logic              err;
  } seg_t;

  localparam seg_t SEG_IDLE = '{data: '0, en: 1'b0, err: 1'b0};

  // Build the segment for an offered byte; the error flag is dropped
  // when the segment will go out at the slow speed.
  function automatic seg_t make_seg(input logic valid, input logic en,
                                    input logic err, input logic [DATA_W-1:0] data,
                                    input logic slow);
    seg_t s;
    if (!valid) begin
      s = SEG_IDLE;
    end else begin
      s.data = data;
      s.en   = en;
      s.err  = err & ~slow;
    end
    return s;
  endfunction

  // Serial bit number idx of a segment.
  function automatic logic seg_bit(input seg_t s, input logic [3:0] idx);
    logic [SEG_W-1:0] flat;
    flat = s;
    return flat[idx];
  endfunction

  // Mode that a segment loaded now will use: a new speed only while idle.
  function automatic logic next_mode(input logic cur_slow, input logic req_slow,
                                     input logic loaded_en);
    return loaded_en ? cur_slow : req_slow;
  endfunction

endpackage

// File: rtl/serial_mii_tx_timer.sv
module serial_mii_tx_timer #(
  parameter int SEG_W = 10,
  localparam int IDX_W = $clog2(SEG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] bit_idx,
  output logic             seg_first,
  output logic             seg_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_W - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_q == LAST_IDX) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_idx   = idx_q;
  assign seg_first = (idx_q == '0);
  assign seg_last  = (idx_q == LAST_IDX);

endmodule

// File: rtl/serial_mii_tx_repeat.sv
module serial_mii_tx_repeat #(
  parameter int REPEAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_last,
  input  logic mode_slow,
  output logic rep_last
);

  generate
    if (REPEAT > 1) begin : g_count
      localparam int REP_W = $clog2(REPEAT);
      localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPEAT - 1);
      logic [REP_W-1:0] rep_q;

      always_ff @(posedge clk) begin
        if (!rst_n || !mode_slow) begin
          rep_q <= '0;
        end else if (seg_last) begin
          rep_q <= (rep_q == LAST_REP) ? '0 : rep_q + 1'b1;
        end
      end

      assign rep_last = (rep_q == LAST_REP);
    end else begin : g_single
      assign rep_last = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/serial_mii_tx_loader.sv
module serial_mii_tx_loader
  import serial_mii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              speed_slow,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_en,
  input  logic              in_err,
  output seg_t              seg_q,
  output logic              mode_slow
);

  logic loaded_en;
  logic mode_next;
  seg_t seg_next;

  always_comb begin
    loaded_en = in_valid & in_en;
    mode_next = next_mode(mode_slow, speed_slow, loaded_en);
    seg_next  = make_seg(in_valid, in_en, in_err, in_data, mode_next);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q     <= SEG_IDLE;
      mode_slow <= 1'b0;
    end else if (take) begin
      seg_q     <= seg_next;
      mode_slow <= mode_next;
    end
  end

endmodule

// File: rtl/serial_mii_tx.sv
module serial_mii_tx
  import serial_mii_tx_pkg::*;
#(
  parameter int SLOW_REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_slow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_en,
  input  logic              in_err,
  output logic              ser_data,
  output logic              ser_sync
);

  localparam int IDX_W = $clog2(SEG_W);

  logic [IDX_W-1:0] bit_idx_w;
  logic             seg_first_w;
  logic             seg_last_w;
  logic             rep_last_w;
  logic             mode_slow_w;
  logic             take_w;
  logic             seg_en_w;
  seg_t             seg_w;

  serial_mii_tx_timer #(.SEG_W(SEG_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_idx   (bit_idx_w),
    .seg_first (seg_first_w),
    .seg_last  (seg_last_w)
  );

  serial_mii_tx_repeat #(.REPEAT(SLOW_REPEAT)) u_repeat (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_last  (seg_last_w),
    .mode_slow (mode_slow_w),
    .rep_last  (rep_last_w)
  );

  // A load point is the last bit of a segment, and at the slow speed only
  // the last bit of its final copy.
  assign take_w = seg_last_w & (~mode_slow_w | rep_last_w);

  serial_mii_tx_loader u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take_w),
    .speed_slow (speed_slow),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_en      (in_en),
    .in_err     (in_err),
    .seg_q      (seg_w),
    .mode_slow  (mode_slow_w)
  );

  assign seg_en_w = seg_w.en;
  assign in_ready = take_w & rst_n;
  assign ser_sync = seg_first_w;
  assign ser_data = seg_bit(seg_w, 4'(bit_idx_w));

endmodule

// File: rtl/serial_mii_tx_chk.sv
module serial_mii_tx_chk #(
  parameter int SEG_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ser_sync,
  input logic ser_data,
  input logic in_ready,
  input logic mode_slow,
  input logic seg_en
);

  localparam int CW = $clog2(SEG_W);
  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= (phase_q == CW'(SEG_W - 1)) ? '0 : phase_q + 1'b1;
  end

  a_r2_sync_period: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sync == (phase_q == '0));

  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  a_r4_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ser_sync);

  a_r7_err_low_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_slow && ser_sync) |-> !ser_data);

  a_r9_mode_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_slow) |-> (ser_sync && !seg_en));

endmodule

bind serial_mii_tx serial_mii_tx_chk #(.SEG_W(10)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_sync  (ser_sync),
  .ser_data  (ser_data),
  .in_ready  (in_ready),
  .mode_slow (mode_slow_w),
  .seg_en    (seg_en_w)
);

// File: tb/serial_mii_tx_test.sv
module serial_mii_tx_test;

  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_slow = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_en = 1'b0;
  logic       in_err = 1'b0;
  logic       ser_data;
  logic       ser_sync;

  int checks = 0;
  int fails  = 0;
  logic bench_slow = 1'b0;
  logic done = 1'b0;
  logic [9:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mii_tx uut (
    .clk(clk), .rst_n(rst_n), .speed_slow(speed_slow),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_en(in_en), .in_err(in_err), .ser_data(ser_data), .ser_sync(ser_sync)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: offer a byte, wait for ready, push the expected segment copies.
  task automatic send(input logic e, input logic er, input logic [7:0] d);
    logic [9:0] seg;
    in_valid = 1'b1; in_en = e; in_err = er; in_data = d;
    while (!in_ready) @(negedge clk);
    seg = {d, e, er & ~bench_slow};
    for (int k = 0; k < (bench_slow ? 10 : 1); k++) exp_q.push_back(seg);
    @(negedge clk);
    in_valid = 1'b0; in_en = 1'b0; in_err = 1'b0;
  endtask

  // Monitor: phase counted from reset release, segment compared at its end.
  initial begin
    int ph = 0;
    logic [9:0] cur = '0;
    logic [9:0] got = '0;
    wait (rst_n);
    forever begin
      if (ph == 0) begin
        cur = (exp_q.size() != 0) ? exp_q.pop_front() : 10'h000;
        check(ser_sync == 1'b1, "R2 sync at segment start", ser_sync, 1);
      end else if (ser_sync) begin
        check(1'b0, "R2 sync outside segment start", ph, 0);
      end
      got[ph] = ser_data;
      if (in_ready) check(ph == 9, "R4 ready only in last bit", ph, 9);
      if (ph == 9)
        check(got == cur, "R3/R5/R6/R7/R8 segment content", got, cur);
      ph = (ph == 9) ? 0 : ph + 1;
      @(negedge clk);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state held in reset
    check(ser_sync == 1'b1, "R1 sync in reset", ser_sync, 1);
    check(ser_data == 1'b0, "R1 data in reset", ser_data, 0);
    check(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    rst_n = 1'b1;
    check(ser_sync && !ser_data && !in_ready, "R1 first cycle after reset",
          {ser_sync, ser_data, in_ready}, 3'b100);

    // R6/R3: fast frame with varied patterns and one error byte
    repeat (23) @(negedge clk);
    send(1, 0, 8'h55);
    send(1, 0, 8'hA3);
    send(1, 1, 8'h0F);     // R6 error passes at 100 Mbps
    send(1, 0, 8'h80);
    send(1, 0, 8'h01);
    // R8: idle segments follow the frame
    repeat (40) @(negedge clk);

    // R9: speed request raised mid-frame is ignored until the frame ends
    send(1, 0, 8'hC6);
    speed_slow = 1'b1;
    send(1, 1, 8'h3C);
    send(1, 0, 8'hFF);
    repeat (30) @(negedge clk);
    bench_slow = 1'b1;
    repeat (120) @(negedge clk);

    // R5/R7: slow frame, error flag dropped, request to leave mid-frame ignored
    send(1, 1, 8'h96);
    speed_slow = 1'b0;
    send(1, 0, 8'h4B);
    send(1, 1, 8'hE1);
    repeat (110) @(negedge clk);
    bench_slow = 1'b0;
    repeat (120) @(negedge clk);

    // R4/R6: back at full speed, back-to-back bytes
    send(1, 1, 8'h12);
    send(1, 0, 8'hED);
    send(0, 0, 8'h77);     // R8-style explicit non-frame byte, enable clear
    repeat (60) @(negedge clk);

    check(exp_q.size() == 0, "R4 all accepted bytes sent", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule